// File: doc/BRIEF.md
# Dual-Input Interleaving SPI Master

This block is an SPI master that reads two slave devices in one frame. A single start strobe begins a frame of exactly sixteen serial clock cycles. The frame uses one shared chip select. Both slaves shift their data out on the same serial clock, each on its own data line. The master samples both lines on every rising clock edge and merges the bits into one 32-bit word. The bits of the two slaves alternate in that word, and the pair received first sits at the top.

The serial clock uses SPI mode 0. It idles low, the inputs are sampled on the rising edge and the slaves change their data on the falling edge. The serial clock is derived from the system clock: each half-period lasts `HALF_CYC` system clocks, so the smallest clock ratio is 2. Each input passes through a two-flop synchronizer. The capture point is delayed by the same number of system clocks, so each bit is taken as it stood at the rising edge.

When the frame ends, the word appears on the result port together with a one-cycle done pulse. It then stays unchanged until the next frame completes. The outgoing data line has no function in this block and is held low.

Top module: `dmspi_master`

## Requirements
- R1: While reset is asserted and on its release, cs_n is 1, sclk is 0, mosi is 0, busy is 0, done is 0 and rx_word is zero.
- R2: A start pulse seen while idle drives cs_n low and busy high on the next system clock edge. The first sclk rising edge follows HALF_CYC system clocks after cs_n falls.
- R3: Each frame has exactly NBITS (16) sclk rising edges. Every high phase and every low phase between rising edges lasts HALF_CYC system clocks, and sclk is high only while cs_n is low.
- R4: cs_n returns high HALF_CYC system clocks after the last sclk falling edge, so cs_n is low for (2*NBITS+1)*HALF_CYC system clocks in total.
- R5: In the result, slave A's k-th received bit (k = 0 is the first) is at rx_word bit 31-2k and slave B's k-th bit is at bit 30-2k.
- R6: Each sampled bit is the level that miso_a and miso_b hold at the sclk rising edge. Slaves that change data on the falling edge are read correctly even at HALF_CYC = 1, despite the synchronizer delay.
- R7: done is high for exactly one system clock, one clock after cs_n returns high, and busy is 0 in that same cycle.
- R8: rx_word changes only in the cycle where done is high.
- R9: A start pulse while busy is 1 is ignored: the frame in progress keeps its length and no extra frame is started.
- R10: mosi stays 0 at all times.
- R11: Whenever busy is 0, cs_n is 1 and sclk is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to run one frame; ignored while busy |
| miso_a | input | 1 | Serial data from slave A |
| miso_b | input | 1 | Serial data from slave B |
| cs_n | output | 1 | Shared chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Outgoing serial data, held low |
| rx_word | output | 2*NBITS | Interleaved result word |
| done | output | 1 | One-cycle pulse when rx_word is updated |
| busy | output | 1 | High from frame start until done |

## Verification
The bench builds the block with HALF_CYC = 1, NBITS = 16 and SYNC_STAGES = 2. At this minimum divider ratio the slave changes its data a single system clock after each rising edge. This gives the two-flop synchronizer the least margin it can have. A capture point off by even one stage therefore returns the neighbouring bit and shows up as a miscompare. The ratio also makes the chip-select lead and lag, the half-period widths and the one-cycle drain before done each a single clock. Any counter that is off by one changes a measured duration.

// File: rtl/dmspi_pkg.sv
// Package: shared types for the dual-input interleaving SPI master.
// Assumes: nothing beyond the standard language.
package dmspi_pkg;

    // Frame controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } dmspi_state_e;

    // Number of slave data lines merged into one word
    localparam int LANES = 2;

endpackage

// File: rtl/dmspi_sync.sv
// Module: dmspi_sync
// Brings one asynchronous serial input into the system clock domain through
// a chain of STAGES flops. Assumes STAGES >= 2; the latency is STAGES clocks.
module dmspi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dmspi_clkgen.sv
// Module: dmspi_clkgen
// Produces the chip select and the mode-0 serial clock for one frame.
// A frame is split into 2*NBITS+1 half-periods of HALF_CYC system clocks:
// one lead half with sclk low, then NBITS high/low pairs, then the lag half.
// rise_evt is high in the cycle before sclk goes high. frame_end is high in
// the cycle before cs_n returns high. Assumes go is only raised while idle.
module dmspi_clkgen #(
    parameter int HALF_CYC = 4,
    parameter int NBITS    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic sclk,
    output logic cs_n,
    output logic rise_evt,
    output logic frame_end
);
    localparam int PHASES = 2 * NBITS + 1;
    localparam int PW     = $clog2(PHASES + 1);
    localparam int CW     = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] half_cnt;
    logic [PW-1:0] phase;
    logic [PW-1:0] phase_nx;
    logic          run_q;
    logic          sclk_q;
    logic          cs_q;
    logic          boundary;
    logic          fall_evt;

    // Decode the end of each half-period and what it starts
    always_comb begin
        boundary  = run_q && (half_cnt == CW'(HALF_CYC - 1));
        phase_nx  = phase + PW'(1);
        frame_end = boundary && (phase_nx == PW'(PHASES));
        rise_evt  = boundary && phase_nx[0] && !frame_end;
        fall_evt  = boundary && !phase_nx[0];
    end

    // Advance the half-period timer and drive sclk and cs_n
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            half_cnt <= '0;
            phase    <= '0;
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
        end else if (go) begin
            run_q    <= 1'b1;
            half_cnt <= '0;
            phase    <= '0;
            sclk_q   <= 1'b0;
            cs_q     <= 1'b0;
        end else if (boundary) begin
            half_cnt <= '0;
            phase    <= phase_nx;
            if (rise_evt) begin
                sclk_q <= 1'b1;
            end
            if (fall_evt) begin
                sclk_q <= 1'b0;
            end
            if (frame_end) begin
                run_q <= 1'b0;
                cs_q  <= 1'b1;
            end
        end else if (run_q) begin
            half_cnt <= half_cnt + CW'(1);
        end
    end

    assign sclk = sclk_q;
    assign cs_n = cs_q;
endmodule

// File: rtl/dmspi_packer.sv
// Module: dmspi_packer
// Collects LANES synchronized bits per sclk rising edge into one shift word.
// The rising-edge strobe is delayed by LAT clocks, matching the synchronizer
// latency, so each capture reads the level present at the edge. din's top
// lane lands in the higher bit of each group; the earliest group ends on top.
// Assumes LAT >= 2 and strobes at least two clocks apart.
module dmspi_packer #(
    parameter int LANES = 2,
    parameter int NBITS = 16,
    parameter int LAT   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rise_evt,
    input  logic [LANES-1:0]       din,
    output logic [LANES*NBITS-1:0] word,
    output logic                   pending
);
    localparam int WW = LANES * NBITS;

    logic [LAT-1:0] strobe_pipe;
    logic [WW-1:0]  shreg;

    // Delay the capture strobe by the synchronizer latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_pipe <= '0;
        end else begin
            strobe_pipe <= {strobe_pipe[LAT-2:0], rise_evt};
        end
    end

    // Shift one group of lane bits in at each delayed strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (strobe_pipe[LAT-1]) begin
            shreg <= {shreg[WW-LANES-1:0], din};
        end
    end

    assign word    = shreg;
    assign pending = |strobe_pipe;
endmodule

// File: rtl/dmspi_master.sv
// Module: dmspi_master (top)
// Runs one frame of NBITS mode-0 serial clocks on start. It reads miso_a and
// miso_b in parallel and presents the bits interleaved (A first in each pair,
// earliest pair at the MSB end) on rx_word with a one-cycle done pulse.
// Assumes HALF_CYC >= 1, SYNC_STAGES >= 2 and slaves that change data on the
// falling sclk edge.
module dmspi_master #(
    parameter int HALF_CYC    = 4,
    parameter int NBITS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               miso_a,
    input  logic               miso_b,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    output logic [2*NBITS-1:0] rx_word,
    output logic               done,
    output logic               busy
);
    import dmspi_pkg::*;

    localparam int WW = LANES * NBITS;

    dmspi_state_e     state;
    logic             go;
    logic             rise_evt;
    logic             frame_end;
    logic             pending;
    logic [LANES-1:0] miso_raw;
    logic [LANES-1:0] miso_sync;
    logic [WW-1:0]    packed_word;
    logic [WW-1:0]    rx_q;
    logic             done_q;

    // Accept a start request only while idle
    assign go = start && (state == ST_IDLE);

    // Lane 1 carries slave A, lane 0 slave B
    assign miso_raw = {miso_a, miso_b};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dmspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (miso_raw[g]),
            .q     (miso_sync[g])
        );
    end

    dmspi_clkgen #(.HALF_CYC(HALF_CYC), .NBITS(NBITS)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .rise_evt  (rise_evt),
        .frame_end (frame_end)
    );

    dmspi_packer #(.LANES(LANES), .NBITS(NBITS), .LAT(SYNC_STAGES)) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_evt (rise_evt),
        .din      (miso_sync),
        .word     (packed_word),
        .pending  (pending)
    );

    // Frame sequencing: run, wait for the last capture, then publish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rx_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (frame_end) begin
                        state <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (!pending) begin
                        rx_q   <= packed_word;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rx_word = rx_q;
    assign done    = done_q;
    assign busy    = (state != ST_IDLE);
    assign mosi    = 1'b0;
endmodule

// File: rtl/dmspi_checker.sv
// Module: dmspi_checker
// Protocol assertions for dmspi_master, attached through bind below.
// Assumes the synchronous active-low reset of the master.
module dmspi_checker #(
    parameter int NBITS = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               cs_n,
    input logic               sclk,
    input logic [2*NBITS-1:0] rx_word,
    input logic               done,
    input logic               busy
);
    localparam int RW = $clog2(NBITS + 1) + 1;

    logic [RW-1:0] rises;
    logic          sclk_d;

    // Count sclk rising edges within the current chip-select window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rises  <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk;
            if (cs_n) begin
                rises <= '0;
            end else if (sclk && !sclk_d) begin
                rises <= rises + RW'(1);
            end
        end
    end

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !cs_n));

    p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    p_edge_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rises == RW'(NBITS)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_word));

    p_cs_fall_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(!busy));

    p_idle_lines_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk));
endmodule

bind dmspi_master dmspi_checker #(.NBITS(NBITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .rx_word (rx_word),
    .done    (done),
    .busy    (busy)
);

// File: tb/sim_dmspi_master.sv
// Scoreboard bench for dmspi_master: the driver pushes expected words, and a
// monitor sampling on the falling system clock checks results and timing.
module sim_dmspi_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 1;
    localparam int NB         = 16;

    logic          clk;
    logic          rst_n;
    logic          start;
    logic          miso_a;
    logic          miso_b;
    logic          cs_n;
    logic          sclk;
    logic          mosi;
    logic [31:0]   rx_word;
    logic          done;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];

    dmspi_master #(.HALF_CYC(HALF), .NBITS(NB), .SYNC_STAGES(2)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .miso_a  (miso_a),
        .miso_b  (miso_b),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .rx_word (rx_word),
        .done    (done),
        .busy    (busy)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Slave models: MSB first, present on cs_n fall, advance on sclk fall
    logic [15:0] sa_word = 16'h0;
    logic [15:0] sb_word = 16'h0;
    int fall_idx = 0;
    int base_idx = 0;
    int frames_seen = 0;
    int frames_started = 0;

    always @(negedge sclk) fall_idx = fall_idx + 1;
    always @(negedge cs_n) begin
        base_idx = fall_idx;
        frames_seen = frames_seen + 1;
    end

    function automatic logic pick(input logic [15:0] w, input int k);
        if (k >= 0 && k < 16) return w[15 - k];
        return 1'b0;
    endfunction

    assign miso_a = pick(sa_word, fall_idx - base_idx);
    assign miso_b = pick(sb_word, fall_idx - base_idx);

    // Monitor state
    bit   mon_on = 0;
    logic cs_prev = 1'b1, sclk_prev = 1'b0;
    logic [31:0] rx_prev = '0;
    int cs_low = 0, rises = 0, hi_run = 0, lo_run = 0, since_fall = 0;
    int after_rise = 0;
    bit width_bad = 0, armed = 0, rx_bad = 0, mosi_bad = 0, idle_bad = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (!cs_n && cs_prev) begin
                cs_low = 0; rises = 0; hi_run = 0; lo_run = 0; width_bad = 0;
            end
            if (!cs_n) cs_low++;
            since_fall++;
            if (sclk && !sclk_prev) begin
                rises++;
                if (rises == 1) chk(cs_low == HALF + 1, "R2 lead", cs_low, HALF + 1);
                else if (lo_run != HALF) width_bad = 1;
                hi_run = 0;
            end
            if (!sclk && sclk_prev) begin
                if (hi_run != HALF) width_bad = 1;
                lo_run = 0;
                since_fall = 0;
            end
            if (sclk) hi_run++; else lo_run++;
            if (cs_n && !cs_prev) begin
                chk(cs_low == (2 * NB + 1) * HALF, "R4 cs low length", cs_low, (2 * NB + 1) * HALF);
                chk(rises == NB, "R3 edge count", rises, NB);
                chk(!width_bad, "R3 half widths", width_bad, 0);
                chk(since_fall == HALF, "R4 lag", since_fall, HALF);
                after_rise = 0;
                armed = 1;
            end else if (armed) begin
                after_rise++;
            end
            if (!done && rx_word != rx_prev) rx_bad = 1;
            if (mosi !== 1'b0) mosi_bad = 1;
            if (!busy && (!cs_n || sclk)) idle_bad = 1;
            if (done) begin
                chk(after_rise == 1, "R7 done delay", after_rise, 1);
                chk(!busy, "R7 busy at done", busy, 0);
                armed = 0;
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected result", rx_word, 0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(rx_word == e, "R5 R6 interleaved word", rx_word, e);
                end
            end
            cs_prev   = cs_n;
            sclk_prev = sclk;
            rx_prev   = rx_word;
        end
    end

    task automatic run_frame(input logic [15:0] a, input logic [15:0] b, input bit poke);
        logic [31:0] e;
        for (int k = 0; k < 16; k++) begin
            e[31 - 2 * k] = a[15 - k];
            e[30 - 2 * k] = b[15 - k];
        end
        exp_q.push_back(e);
        sa_word = a;
        sb_word = b;
        start = 1'b1;
        frames_started++;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !cs_n, "R2 start accepted", {busy, cs_n}, 2'b10);
        if (poke) begin
            repeat (9) @(negedge clk);
            start = 1'b1;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        logic [15:0] lf;
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(mosi == 1'b0, "R1 mosi", mosi, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(rx_word == 32'h0, "R1 rx_word", rx_word, 0);
        rst_n = 1'b1;
        rx_prev = rx_word;
        mon_on = 1;
        repeat (2) @(negedge clk);

        run_frame(16'h0000, 16'hFFFF, 0);
        run_frame(16'hFFFF, 16'h0000, 0);
        run_frame(16'hA5A5, 16'h5A5A, 0);
        run_frame(16'h8001, 16'h0001, 0);
        // R9 start pulses during the frame are ignored
        run_frame(16'h1234, 16'hFEDC, 1);
        repeat (40) @(negedge clk);
        chk(frames_seen == frames_started, "R9 frame count", frames_seen, frames_started);
        chk(cs_n && !busy, "R9 stays idle", {cs_n, busy}, 2'b10);

        // Back-to-back frames with computed patterns
        lf = 16'hACE1;
        for (int i = 0; i < 6; i++) begin
            logic [15:0] a2;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a2 = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run_frame(a2, lf, 0);
        end
        repeat (5) @(negedge clk);
        chk(frames_seen == frames_started, "R9 total frames", frames_seen, frames_started);
        chk(!rx_bad, "R8 result held between done pulses", rx_bad, 0);
        chk(!mosi_bad, "R10 mosi low", mosi_bad, 0);
        chk(!idle_bad, "R11 idle lines", idle_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule